// File: doc/BRIEF.md
# Timer with Edge Capture and Match Actions

This block is a free-running binary up-counter with one capture channel and a bank of match channels. Software programs it through a flat register port with a write strobe and a separate read address. Read data comes back one clock after the address. The counter advances by one on every clock while its run bit is set, and software can load it directly at any time.

The capture channel takes an asynchronous input and passes it through a two-flop synchronizer. It remembers the last synchronized level. On a selected transition it copies the counter into the capture register. The transition can be a rising edge, a falling edge, or either one. Each match channel compares its own register with the running counter on every clock. On equality it can do any mix of three things: raise an interrupt flag, return the counter to zero, or halt counting.

All interrupt causes land in one sticky flag register, and software clears a flag by writing a 1 to its bit. The single interrupt output is registered and is high whenever any flag is set.

Top module: `cap_match_timer`

Register addresses (4-bit): 0 RUN (bit 0 = count enable), 1 COUNT (counter value, writable), 2 MATCH_CFG, 3 CAP_CFG, 4 CAPTURE (read only), 5 FLAGS, 8+i MATCH register of channel i. For channel i, MATCH_CFG bit 3i enables its interrupt, bit 3i+1 enables counter reset and bit 3i+2 enables stop. CAP_CFG bit 0 selects rising edges, bit 1 falling edges, and bit 2 enables the capture interrupt. FLAGS bit i (i < 4) is the match flag of channel i, and bit 4 is the capture flag.

## Requirements
- R1: After reset the counter, RUN, MATCH_CFG, CAP_CFG, CAPTURE, FLAGS and all match registers read 0, and irq is low.
- R2: While RUN bit 0 is 1 the counter increases by one per clock. A write to COUNT loads the written value.
- R3: With CAP_CFG bit 0 set, a 0-to-1 change of the synchronized capture input loads the counter value into CAPTURE.
- R4: With CAP_CFG bit 1 set, a 1-to-0 change of the synchronized capture input loads the counter value into CAPTURE. When only one edge bit is set, the other edge leaves CAPTURE unchanged.
- R5: With CAP_CFG bits 0 and 1 both set, every transition of the input loads CAPTURE.
- R6: With CAP_CFG bits 0 and 1 both clear, transitions of the input leave CAPTURE unchanged.
- R7: When CAP_CFG bit 2 is set, each capture load sets FLAGS bit 4. With bit 2 clear, a capture load leaves FLAGS bit 4 at 0.
- R8: While counting, equality of the counter and MATCH register i with MATCH_CFG bit 3i set sets FLAGS bit i.
- R9: While counting, equality on channel i with MATCH_CFG bit 3i+1 set makes the counter 0 on the next clock, so the count wraps with period MATCH+1.
- R10: While counting, equality on channel i with MATCH_CFG bit 3i+2 set clears RUN bit 0. The counter then holds the matched value.
- R11: When a software write to COUNT and a match reset fall in the same clock, the counter becomes 0.
- R12: FLAGS bits stay set until software writes 1 to them. irq is high exactly when some FLAGS bit is set, and it follows FLAGS in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data, valid one clock after rd_addr |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Registered interrupt request, OR of all flags |

## Verification
Several properties are checked on every cycle. These are the one-step count increment, a match reset forcing zero even against a counter write, a stop clearing the run bit and freezing the count, the capture register taking the previous counter value, flag stickiness, and irq agreeing with the flags. Some behaviour can only be shown by the bench scenarios, because it spans register programming and many cycles. This covers the selection of rising, falling, both or no edges, the wrap period set by a reset match, masking of the capture interrupt, and write-one-to-clear.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_RUN    = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MCFG   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CCFG   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAPT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;

  // Per-channel match action bits, in MATCH_CFG order (irq lowest)
  typedef struct packed {
    logic stop;
    logic zero;
    logic irq;
  } match_act_t;

  // Capture configuration bits
  typedef struct packed {
    logic irq;
    logic fall;
    logic rise;
  } cap_cfg_t;
endpackage

// File: rtl/cmt_edge_detect.sv
module cmt_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_en,
  input  logic fall_en,
  output logic evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];
  assign evt = (rise_en & cur & ~prev_q) | (fall_en & ~cur & prev_q);

  // R6: with neither edge selected no capture event is produced
  p_no_event_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!rise_en && !fall_en) |-> !evt);
endmodule

// File: rtl/cmt_match_bank.sv
module cmt_match_bank
  import cmt_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic           run,
  input  logic [W-1:0]   cnt,
  input  logic [N*W-1:0] match_flat,
  input  logic [3*N-1:0] cfg,
  output logic [N-1:0]   irq_hits,
  output logic           zero_req,
  output logic           stop_req
);
  logic [N-1:0] zero_v;
  logic [N-1:0] stop_v;

  for (genvar i = 0; i < N; i++) begin : g_ch
    match_act_t act;
    logic       hit;
    assign act         = match_act_t'(cfg[3*i +: 3]);
    assign hit         = run && (cnt == match_flat[i*W +: W]);
    assign irq_hits[i] = hit & act.irq;
    assign zero_v[i]   = hit & act.zero;
    assign stop_v[i]   = hit & act.stop;
  end

  assign zero_req = |zero_v;
  assign stop_req = |stop_v;
endmodule

// File: rtl/cap_match_timer.sv
module cap_match_timer
  import cmt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_MATCH   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cap_in,
  output logic              irq
);
  localparam int CFG_W  = 3 * NUM_MATCH;
  localparam int FLAG_W = NUM_MATCH + 1;
  localparam int CAP_FLAG = NUM_MATCH;

  logic              run_q;
  logic [DATA_W-1:0] cnt_q;
  logic [CFG_W-1:0]  mcfg_q;
  cap_cfg_t          ccfg_q;
  logic [DATA_W-1:0] cap_q;
  logic [FLAG_W-1:0] flags_q, flags_d, flag_clr, flag_set;
  logic [DATA_W-1:0] match_q [NUM_MATCH];
  logic [NUM_MATCH*DATA_W-1:0] match_flat;
  logic [DATA_W-1:0] rd_q;
  logic              irq_q;

  logic [NUM_MATCH-1:0] irq_hits;
  logic zero_req, stop_req, cap_evt;
  logic wr_run, wr_cnt, wr_mcfg, wr_ccfg, wr_flags;

  assign wr_run   = wr_en && (wr_addr == A_RUN);
  assign wr_cnt   = wr_en && (wr_addr == A_COUNT);
  assign wr_mcfg  = wr_en && (wr_addr == A_MCFG);
  assign wr_ccfg  = wr_en && (wr_addr == A_CCFG);
  assign wr_flags = wr_en && (wr_addr == A_FLAGS);

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    always_ff @(posedge clk) begin
      if (rst) match_q[i] <= '0;
      else if (wr_en && (wr_addr == A_MATCH0 + ADDR_W'(i))) match_q[i] <= wr_data;
    end
    assign match_flat[i*DATA_W +: DATA_W] = match_q[i];
  end

  cmt_match_bank #(.W(DATA_W), .N(NUM_MATCH)) u_bank (
    .run       (run_q),
    .cnt       (cnt_q),
    .match_flat(match_flat),
    .cfg       (mcfg_q),
    .irq_hits  (irq_hits),
    .zero_req  (zero_req),
    .stop_req  (stop_req)
  );

  cmt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .din    (cap_in),
    .rise_en(ccfg_q.rise),
    .fall_en(ccfg_q.fall),
    .evt    (cap_evt)
  );

  // Counter: match reset beats a software load, which beats stop/hold
  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (zero_req) cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wr_data;
    else if (stop_req) cnt_q <= cnt_q;
    else if (run_q)    cnt_q <= cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           run_q <= 1'b0;
    else if (stop_req) run_q <= 1'b0;
    else if (wr_run)   run_q <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcfg_q <= '0;
      ccfg_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_mcfg) mcfg_q <= wr_data[CFG_W-1:0];
      if (wr_ccfg) ccfg_q <= cap_cfg_t'(wr_data[2:0]);
      if (cap_evt) cap_q  <= cnt_q;
    end
  end

  // Sticky flags: a new cause wins over a clear in the same clock
  assign flag_clr = wr_flags ? wr_data[FLAG_W-1:0] : '0;
  assign flag_set = {cap_evt & ccfg_q.irq, irq_hits};
  assign flags_d  = (flags_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |flags_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      case (rd_addr)
        A_RUN:   rd_q <= DATA_W'(run_q);
        A_COUNT: rd_q <= cnt_q;
        A_MCFG:  rd_q <= DATA_W'(mcfg_q);
        A_CCFG:  rd_q <= DATA_W'(ccfg_q);
        A_CAPT:  rd_q <= cap_q;
        A_FLAGS: rd_q <= DATA_W'(flags_q);
        default: begin
          for (int i = 0; i < NUM_MATCH; i++)
            if (rd_addr == A_MATCH0 + ADDR_W'(i)) rd_q <= match_q[i];
        end
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R9 and R11: a match reset leaves zero, whatever software wrote
  p_zero_after_match_r9: assert property (@(posedge clk) disable iff (rst)
    $past(zero_req) |-> (cnt_q == '0));
  p_stop_clears_run_r10: assert property (@(posedge clk) disable iff (rst)
    $past(stop_req) |-> !run_q);
  p_stop_holds_r10: assert property (@(posedge clk) disable iff (rst)
    $past(stop_req && !zero_req && !wr_cnt) |-> (cnt_q == $past(cnt_q)));
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    $past(run_q && !zero_req && !stop_req && !wr_cnt) |->
      (cnt_q == $past(cnt_q) + DATA_W'(1)));
  p_capture_load_r3: assert property (@(posedge clk) disable iff (rst)
    $past(cap_evt) |-> (cap_q == $past(cnt_q)));
  p_flags_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (($past(flags_q) & ~$past(flag_clr) & ~flags_q) == '0));
  p_irq_follows_flags_r12: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags_q));
endmodule

// File: tb/cap_match_timer_test.sv
`timescale 1ns/1ps
module cap_match_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cap_in = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [3:0] RUN = 4'd0, COUNT = 4'd1, MCFG = 4'd2, CCFG = 4'd3,
                         CAPT = 4'd4, FLAGS = 4'd5, MATCH0 = 4'd8;

  always #4 clk = ~clk;

  cap_match_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cap(input logic v);
    cap_in = v;
    idle(6);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      check("R1", $sformatf("reg %0d after reset", a), v, 32'd0);
    end
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(COUNT, 32'd1000);
    rd(COUNT, v);
    check("R2", "counter load", v, 32'd1000);
    wr(RUN, 32'd1);
    idle(9);
    wr(RUN, 32'd0);
    rd(COUNT, v);
    check("R2", "ten clocks of counting", v, 32'd1010);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr(CCFG, 32'd1);
    wr(COUNT, 32'd123);
    set_cap(1'b1);
    rd(CAPT, v);  check("R3", "rising edge captured", v, 32'd123);
    wr(COUNT, 32'd200);
    set_cap(1'b0);
    rd(CAPT, v);  check("R4", "falling edge ignored in rise mode", v, 32'd123);
    rd(FLAGS, v); check("R7", "no capture flag when masked", v, 32'd0);
    wr(CCFG, 32'd2);
    wr(COUNT, 32'd300);
    set_cap(1'b1);
    rd(CAPT, v);  check("R4", "rising edge ignored in fall mode", v, 32'd123);
    set_cap(1'b0);
    rd(CAPT, v);  check("R4", "falling edge captured", v, 32'd300);
    wr(CCFG, 32'd3);
    wr(COUNT, 32'd400);
    set_cap(1'b1);
    rd(CAPT, v);  check("R5", "both mode rising", v, 32'd400);
    wr(COUNT, 32'd500);
    set_cap(1'b0);
    rd(CAPT, v);  check("R5", "both mode falling", v, 32'd500);
    wr(CCFG, 32'd0);
    wr(COUNT, 32'd600);
    set_cap(1'b1);
    set_cap(1'b0);
    rd(CAPT, v);  check("R6", "capture disabled", v, 32'd500);
    wr(CCFG, 32'd5);
    wr(COUNT, 32'd700);
    set_cap(1'b1);
    rd(CAPT, v);  check("R7", "capture with irq", v, 32'd700);
    rd(FLAGS, v); check("R7", "capture flag bit 4", v, 32'h10);
    check("R7", "irq from capture", {31'd0, irq}, 32'd1);
    wr(FLAGS, 32'h10);
    rd(FLAGS, v); check("R12", "capture flag cleared", v, 32'd0);
    wr(CCFG, 32'd0);
  endtask

  task automatic t_match_irq;
    logic [31:0] v;
    wr(MCFG, 32'h1);
    wr(MATCH0, 32'd20);
    wr(COUNT, 32'd0);
    wr(RUN, 32'd1);
    idle(30);
    wr(RUN, 32'd0);
    rd(FLAGS, v); check("R8", "match 0 flag", v, 32'd1);
    check("R12", "irq with match flag", {31'd0, irq}, 32'd1);
    idle(5);
    rd(FLAGS, v); check("R12", "flag sticky", v, 32'd1);
    wr(FLAGS, 32'h2);
    rd(FLAGS, v); check("R12", "writing 1 to other bit keeps flag", v, 32'd1);
    wr(FLAGS, 32'h1);
    rd(FLAGS, v); check("R12", "flag cleared by write of 1", v, 32'd0);
    check("R12", "irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_match_reset;
    logic [31:0] v;
    wr(MCFG, 32'h10);            // channel 1 reset (bit 4)
    wr(MATCH0 + 4'd1, 32'd10);
    wr(COUNT, 32'd0);
    wr(RUN, 32'd1);
    idle(24);
    wr(RUN, 32'd0);
    rd(COUNT, v); check("R9", "wrap period 11 after 25 clocks", v, 32'd3);
    rd(FLAGS, v); check("R8", "no flag without irq bit", v, 32'd0);
    wr(COUNT, 32'd5);
    wr(RUN, 32'd1);
    idle(5);
    wr(COUNT, 32'd77);           // lands in the clock the counter equals 10
    wr(RUN, 32'd0);
    rd(COUNT, v); check("R11", "match reset beats software write", v, 32'd1);
  endtask

  task automatic t_match_stop;
    logic [31:0] v;
    wr(MCFG, 32'h100);           // channel 2 stop (bit 8)
    wr(MATCH0 + 4'd2, 32'd15);
    wr(COUNT, 32'd0);
    wr(RUN, 32'd1);
    idle(40);
    rd(RUN, v);   check("R10", "run bit cleared by stop", v, 32'd0);
    rd(COUNT, v); check("R10", "counter holds matched value", v, 32'd15);
    idle(10);
    rd(COUNT, v); check("R10", "counter still held", v, 32'd15);
    wr(MCFG, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_count();
    t_capture();
    t_match_irq();
    t_match_reset();
    t_match_stop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule